// File: doc/BRIEF.md
# Four-Channel Break Condition Combiner

This block sits behind four comparator channels of a debug break unit. Channels 3 and 2 watch the operand address bus. Channels 1 and 0 watch the data value bus. Each channel either tests its bus for equality against its own compare value, or works with its partner as one half of a range. The block can cross-combine the address pair with the data pair, so that a break fires only when an operand address condition and a data value condition hold in the same cycle.

The combined bits are latched into four sticky break bits. Software clears them by writing ones. An operand-break request is raised while any sticky bit is set and the unit is in break mode. When the group is switched to memory protection mode, combination has no effect on the break bits and no request is raised.

Top module: `brk_combiner`

## Requirements
- R1: A raw channel match occurs only in a cycle where that channel's bus qualifier is high. Channels 3 and 2 compare against `addr_bus` under `addr_vld`. Channels 1 and 0 compare against `data_bus` under `data_vld`. With its pair's range enable clear, a channel matches when the bus equals its own compare value.
- R2: With a pair's range enable set, the upper channel (3 or 1) holds the start and the lower channel (2 or 0) holds the end, and start < end is assumed. A bus value equal to the start sets only the upper raw bit. A value strictly between start and end sets both raw bits. A value equal to the end sets only the lower raw bit. Values outside [start, end] set neither.
- R3: With `cfg_comb` low, each raw bit passes unchanged to the break bit with the same index.
- R4: With `cfg_comb` high, `cfg_prot` low, `cfg_type` = 3 and both range enables clear, bits 3 and 1 both take raw3 AND raw1, and bits 2 and 0 both take raw2 AND raw0.
- R5: Under the same mode but with either range enable set, bit 3 takes raw3 AND (raw1 OR raw0), and bit 2 takes raw2 AND (raw1 OR raw0). Bit 1 takes raw1 AND (raw3 OR raw2), and bit 0 takes raw0 AND (raw3 OR raw2).
- R6: With `cfg_type` other than 3, the raw bits pass through as in R3, whatever the value of `cfg_comb`.
- R7: With `cfg_prot` high, the raw bits pass through as in R3, and `brk_req` stays low.
- R8: Break bits are sticky. A bit is set at the clock edge when its combined condition is true. It is cleared at an edge where the matching `clr_bits` bit is 1 and the condition is false. If set and clear happen in the same cycle, the set wins.
- R9: `brk_req` is high exactly when any break bit is set and `cfg_prot` is low.
- R10: A change of any configuration input does not clear latched break bits. The new configuration governs from the next edge on.
- R11: While `rst_n` is low, all break bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_bus | input | W | Operand address under test |
| addr_vld | input | 1 | Operand access valid this cycle |
| data_bus | input | W | Data value under test |
| data_vld | input | 1 | Data access valid this cycle |
| cmp_val3 | input | W | Channel 3 compare value (address, range start) |
| cmp_val2 | input | W | Channel 2 compare value (address, range end) |
| cmp_val1 | input | W | Channel 1 compare value (data, range start) |
| cmp_val0 | input | W | Channel 0 compare value (data, range end) |
| cfg_comb | input | 1 | Channel combination enable |
| cfg_prot | input | 1 | Protection mode select (1) versus break mode (0) |
| cfg_type | input | 2 | Channel-type code; 3 pairs operand address with data value |
| cfg_rng_addr | input | 1 | Range enable for channels 3/2 |
| cfg_rng_data | input | 1 | Range enable for channels 1/0 |
| clr_bits | input | 4 | Write-one-to-clear strobe per break bit |
| brk_bits | output | 4 | Sticky break-detection bits |
| brk_req | output | 1 | Operand-break request |

## Verification
A new break condition and a software clear of the same bit can land on one clock edge. The clear path and the set path then compete for one flop. The bench provokes this in two ways. A directed case makes a match and strobes the clear of that same bit in the same cycle. The random phase also drives clear masks freely alongside matching bus values. The reference model judges each edge: the result must be the old bits with the cleared ones removed, ORed with the newly combined bits, so a coinciding set always survives.

// File: rtl/brk_combiner.sv
module brk_combiner #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] addr_bus,
  input  logic         addr_vld,
  input  logic [W-1:0] data_bus,
  input  logic         data_vld,
  input  logic [W-1:0] cmp_val3,
  input  logic [W-1:0] cmp_val2,
  input  logic [W-1:0] cmp_val1,
  input  logic [W-1:0] cmp_val0,
  input  logic         cfg_comb,
  input  logic         cfg_prot,
  input  logic [1:0]   cfg_type,
  input  logic         cfg_rng_addr,
  input  logic         cfg_rng_data,
  input  logic [3:0]   clr_bits,
  output logic [3:0]   brk_bits,
  output logic         brk_req
);

  localparam logic [1:0] TYPE_OA_DT = 2'd3;
  localparam int NPAIR = 2;

  logic [W-1:0] pr_bus [NPAIR];
  logic         pr_vld [NPAIR];
  logic         pr_rng [NPAIR];
  logic [W-1:0] pr_start [NPAIR];
  logic [W-1:0] pr_end [NPAIR];

  assign pr_bus[0]   = data_bus;
  assign pr_vld[0]   = data_vld;
  assign pr_rng[0]   = cfg_rng_data;
  assign pr_start[0] = cmp_val1;
  assign pr_end[0]   = cmp_val0;
  assign pr_bus[1]   = addr_bus;
  assign pr_vld[1]   = addr_vld;
  assign pr_rng[1]   = cfg_rng_addr;
  assign pr_start[1] = cmp_val3;
  assign pr_end[1]   = cmp_val2;

  logic [3:0] raw;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic at_start, at_end, above_start, below_end;
    assign at_start    = pr_bus[p] == pr_start[p];
    assign at_end      = pr_bus[p] == pr_end[p];
    assign above_start = pr_bus[p] >  pr_start[p];
    assign below_end   = pr_bus[p] <  pr_end[p];

    assign raw[2*p+1] = pr_vld[p] &&
      (pr_rng[p] ? ((at_start || above_start) && below_end) : at_start);
    assign raw[2*p]   = pr_vld[p] &&
      (pr_rng[p] ? (above_start && (below_end || at_end)) : at_end);
  end

  logic       comb_on, rng_any;
  logic [3:0] cond;

  assign comb_on = cfg_comb && !cfg_prot && (cfg_type == TYPE_OA_DT);
  assign rng_any = cfg_rng_addr || cfg_rng_data;

  always_comb begin
    cond = raw;
    if (comb_on) begin
      if (!rng_any) begin
        cond[3] = raw[3] && raw[1];
        cond[1] = raw[3] && raw[1];
        cond[2] = raw[2] && raw[0];
        cond[0] = raw[2] && raw[0];
      end else begin
        cond[3] = raw[3] && (raw[1] || raw[0]);
        cond[2] = raw[2] && (raw[1] || raw[0]);
        cond[1] = raw[1] && (raw[3] || raw[2]);
        cond[0] = raw[0] && (raw[3] || raw[2]);
      end
    end
  end

  logic [3:0] brk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) brk_q <= '0;
    else        brk_q <= (brk_q & ~clr_bits) | cond;
  end

  assign brk_bits = brk_q;
  assign brk_req  = (|brk_q) && !cfg_prot;

endmodule

module brk_combiner_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       addr_vld,
  input logic       data_vld,
  input logic       cfg_comb,
  input logic       cfg_prot,
  input logic [1:0] cfg_type,
  input logic       cfg_rng_addr,
  input logic       cfg_rng_data,
  input logic [3:0] clr_bits,
  input logic [3:0] brk_bits,
  input logic       brk_req
);

  AST_NO_MATCH_WITHOUT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_vld && !data_vld && clr_bits == 4'hF) |=> (brk_bits == 4'h0)); // R1

  AST_PAIRED_AND: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_comb && !cfg_prot && cfg_type == 2'd3 && !cfg_rng_addr && !cfg_rng_data && clr_bits == 4'hF)
    |=> (brk_bits[3] == brk_bits[1] && brk_bits[2] == brk_bits[0])); // R4

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((brk_bits & $past(brk_bits & ~clr_bits)) == $past(brk_bits & ~clr_bits))); // R8

  AST_PROT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_prot |-> !brk_req); // R7

  AST_REQ_ON_ANY: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_prot && brk_bits != 4'h0) |-> brk_req); // R9

  AST_REQ_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> (brk_bits != 4'h0)); // R9

endmodule

bind brk_combiner brk_combiner_chk u_brk_combiner_chk (.*);

// File: tb/brk_combiner_bench.sv
module brk_combiner_bench;
  localparam int W = 32;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] addr_bus = '0, data_bus = '0;
  logic addr_vld = 1'b0, data_vld = 1'b0;
  logic [W-1:0] v3 = '0, v2 = '0, v1 = '0, v0 = '0;
  logic cfg_comb = 1'b0, cfg_prot = 1'b0, cfg_rng_addr = 1'b0, cfg_rng_data = 1'b0;
  logic [1:0] cfg_type = 2'd0;
  logic [3:0] clr_bits = 4'h0;
  logic [3:0] brk_bits;
  logic brk_req;

  int total = 0, bad = 0;
  logic [3:0] exp_q = 4'h0;
  string tag_now;

  always #(CLK_PERIOD/2) clk = ~clk;

  brk_combiner #(.W(W)) u_brk_combiner (
    .clk(clk), .rst_n(rst_n),
    .addr_bus(addr_bus), .addr_vld(addr_vld),
    .data_bus(data_bus), .data_vld(data_vld),
    .cmp_val3(v3), .cmp_val2(v2), .cmp_val1(v1), .cmp_val0(v0),
    .cfg_comb(cfg_comb), .cfg_prot(cfg_prot), .cfg_type(cfg_type),
    .cfg_rng_addr(cfg_rng_addr), .cfg_rng_data(cfg_rng_data),
    .clr_bits(clr_bits), .brk_bits(brk_bits), .brk_req(brk_req));

  // Two-bit raw result for one pair: {upper, lower}
  function automatic logic [1:0] pair_raw(input logic vld, input logic rng,
      input logic [W-1:0] bus, input logic [W-1:0] s, input logic [W-1:0] e);
    logic [1:0] r;
    r = 2'b00;
    if (vld) begin
      if (!rng) r = {bus == s, bus == e};
      else if (bus == s) r = 2'b10;
      else if (bus == e) r = 2'b01;
      else if (bus > s && bus < e) r = 2'b11;
    end
    return r;
  endfunction

  function automatic logic [3:0] model_cond();
    logic [3:0] r, c;
    r = {pair_raw(addr_vld, cfg_rng_addr, addr_bus, v3, v2),
         pair_raw(data_vld, cfg_rng_data, data_bus, v1, v0)};
    c = r;
    if (cfg_comb && !cfg_prot && cfg_type == 2'd3) begin
      if (!cfg_rng_addr && !cfg_rng_data)
        c = {r[3] & r[1], r[2] & r[0], r[3] & r[1], r[2] & r[0]};
      else
        c = {r[3] & (r[1] | r[0]), r[2] & (r[1] | r[0]),
             r[1] & (r[3] | r[2]), r[0] & (r[3] | r[2])};
    end
    return c;
  endfunction

  function automatic string mode_tag();
    if (cfg_prot) return "R7";
    if (!cfg_comb) return "R3";
    if (cfg_type != 2'd3) return "R6";
    if (cfg_rng_addr || cfg_rng_data) return "R5";
    return "R4";
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Inputs are already driven (after a negedge); clock one edge and compare.
  task automatic step(input string tag);
    exp_q = (exp_q & ~clr_bits) | model_cond();
    @(posedge clk);
    @(negedge clk);
    check(tag, brk_bits, exp_q);
    check("R9", {3'b0, brk_req}, {3'b0, (|exp_q) && !cfg_prot});
  endtask

  task automatic idle_clear();
    addr_vld = 0; data_vld = 0; clr_bits = 4'hF;
    step("R8");
    clr_bits = 4'h0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5eed_1234);
    v3 = 32'h100; v2 = 32'h108; v1 = 32'hA0; v0 = 32'hA4;
    addr_bus = 32'h100; data_bus = 32'hA0; addr_vld = 1; data_vld = 1;
    repeat (3) @(negedge clk);
    check("R11", brk_bits, 4'h0);
    exp_q = 4'h0;
    addr_vld = 0; data_vld = 0;
    rst_n = 1;
    @(negedge clk);

    // R1: equality needs valid qualifier
    addr_bus = 32'h108; data_bus = 32'hA4;
    step("R1");
    addr_vld = 1; data_vld = 1;
    step("R1");
    check("R1", brk_bits, 4'b0101);
    idle_clear();

    // R2: range edges on the address pair, start/inside/end/outside
    cfg_rng_addr = 1; addr_vld = 1;
    clr_bits = 4'hF;
    addr_bus = 32'h100; step("R2"); check("R2", brk_bits, 4'b1000);
    addr_bus = 32'h104; step("R2"); check("R2", brk_bits, 4'b1100);
    addr_bus = 32'h108; step("R2"); check("R2", brk_bits, 4'b0100);
    addr_bus = 32'h109; step("R2"); check("R2", brk_bits, 4'b0000);
    addr_bus = 32'h0FF; step("R2"); check("R2", brk_bits, 4'b0000);
    cfg_rng_addr = 0; clr_bits = 4'h0;
    idle_clear();

    // R4: combined, no range: address hit alone gives nothing
    cfg_comb = 1; cfg_type = 2'd3;
    addr_vld = 1; addr_bus = 32'h100; data_vld = 0;
    step("R4"); check("R4", brk_bits, 4'b0000);
    data_vld = 1; data_bus = 32'hA0;
    step("R4"); check("R4", brk_bits, 4'b1010);
    idle_clear();

    // R8: set and clear of the same bit on one edge, set wins
    cfg_comb = 0;
    addr_vld = 1; addr_bus = 32'h100; data_vld = 0;
    step("R8");
    clr_bits = 4'b1000;
    step("R8"); check("R8", brk_bits, 4'b1000);
    addr_vld = 0;
    step("R8"); check("R8", brk_bits, 4'b0000);
    clr_bits = 4'h0;

    // R10: config change keeps latched bits
    addr_vld = 1; addr_bus = 32'h108;
    step("R10");
    addr_vld = 0; cfg_comb = 1; cfg_type = 2'd1; cfg_rng_data = 1; cfg_prot = 1;
    step("R10"); check("R10", brk_bits, 4'b0100);
    cfg_prot = 0; cfg_comb = 0; cfg_type = 2'd0; cfg_rng_data = 0;
    idle_clear();

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      logic [W-1:0] sa, sd;
      sa = $urandom_range(0, 255) << 4;
      sd = $urandom_range(0, 255) << 4;
      if ($urandom_range(0, 15) == 0) begin
        v3 = sa; v2 = sa + 1 + $urandom_range(0, 6);
        v1 = sd; v0 = sd + 1 + $urandom_range(0, 6);
      end
      cfg_comb = $urandom_range(0, 3) != 0;
      cfg_prot = $urandom_range(0, 7) == 0;
      cfg_type = ($urandom_range(0, 3) != 0) ? 2'd3 : 2'($urandom_range(0, 2));
      cfg_rng_addr = $urandom_range(0, 1);
      cfg_rng_data = $urandom_range(0, 2) == 0;
      addr_vld = $urandom_range(0, 5) != 0;
      data_vld = $urandom_range(0, 5) != 0;
      addr_bus = v3 + W'($urandom_range(0, 9)) - 1;
      data_bus = v1 + W'($urandom_range(0, 9)) - 1;
      clr_bits = ($urandom_range(0, 2) == 0) ? 4'($urandom_range(0, 15)) : 4'h0;
      tag_now = mode_tag();
      step(tag_now);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule